// File: doc/BRIEF.md
# Banked Bus Window Bridge

This bridge gives a small 8-bit processor with a 16-bit address space access to a 24-bit, 16-bit-wide main system bus. The upper 32 KB of the small processor's address space acts as a window. A 9-bit bank register selects which 32 KB slice of the main bus appears in that window. Each access through the window becomes one arbitrated main-bus cycle. The bridge raises a bus request to the main processor and waits for the grant. It then runs a single byte cycle, selecting the byte lane and its strobe from address bit 0. A write places the byte on both lanes. A read returns one of the two lanes.

The main work-RAM region is treated differently. Writes into it go through as usual, but reads from it always give back a fixed fill byte. While the main-bus cycle is in progress, the small processor is held by a wait line.

The state machine has four states, all driven by one process for the state register and one for outputs:

- Idle: no request is raised.
- Ask: the bus request is raised and the bridge waits for the grant.
- Cycle: the address strobe and one data strobe are active, and the bridge waits for the acknowledge.
- Release: the bus request is still held for one final cycle and read data is valid.

The transitions between them are:

- Idle→Ask on a start pulse with address bit 15 set.
- Ask→Cycle when the grant is seen.
- Cycle→Release when the acknowledge is seen.
- Release→Idle unconditionally.

Top module: `bank_window_bridge`

## Requirements
- R1: After reset the bank register holds 0, and `mbus_req`, `cpu_wait`, `mbus_as`, `mbus_uds` and `mbus_lds` are all low (all control signals are active high).
- R2: A `cpu_req` pulse with `cpu_addr[15]` = 0 is ignored. No bus request is raised and `cpu_wait` stays low.
- R3: During the bus cycle, `mbus_addr[23:15]` equals the bank value captured at the start of the access, and `mbus_addr[14:1]` equals `cpu_addr[14:1]` of that access.
- R4: The bridge raises `mbus_req` the cycle after an accepted start pulse. `mbus_as` stays low until `mbus_grant` has been seen, and it is high only while the grant is held.
- R5: On a read outside work RAM, `cpu_rdata` is `mbus_rdata[7:0]` when `cpu_addr[0]` = 1 and `mbus_rdata[15:8]` when `cpu_addr[0]` = 0.
- R6: On a write, `mbus_rnw` = 0 and `mbus_wdata` carries `cpu_wdata` in both bytes. On any access, `mbus_uds` is asserted alone when `cpu_addr[0]` = 0 and `mbus_lds` is asserted alone when it is 1. On a read, `mbus_rnw` = 1.
- R7: Work RAM is the bank values whose bits 8:1 are all ones, that is main address 0xFF0000–0xFFFFFF. A read there returns 0xFF whatever the bus returns. A write there runs a normal bus cycle with R3/R6 signalling.
- R8: `cpu_wait` is high from the cycle after the start pulse until the cycle in which `mbus_ack` is sampled, and low in the cycle after that.
- R9: `mbus_req` stays high for exactly one cycle after the acknowledged cycle, then drops.
- R10: A bank write takes effect on the next accepted access. A bank write made while an access is in progress does not change that access's address.
- R11: A `cpu_req` pulse that arrives while an access is in progress is ignored. It neither alters the running cycle nor starts a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cpu_req | input | 1 | One-cycle access start pulse |
| cpu_addr | input | 16 | Small-processor address |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_wdata | input | 8 | Write byte |
| cpu_rdata | output | 8 | Read byte, valid once `cpu_wait` falls |
| cpu_wait | output | 1 | Stall to small processor |
| bank_we | input | 1 | Bank register load strobe |
| bank_wdata | input | 9 | New bank value |
| mbus_req | output | 1 | Bus request to main processor |
| mbus_grant | input | 1 | Bus grant from main processor |
| mbus_addr | output | 23 | Main-bus address bits 23:1 |
| mbus_as | output | 1 | Address strobe |
| mbus_rnw | output | 1 | 1 = read, 0 = write |
| mbus_uds | output | 1 | Upper (15:8) data strobe |
| mbus_lds | output | 1 | Lower (7:0) data strobe |
| mbus_wdata | output | 16 | Write data, byte replicated |
| mbus_rdata | input | 16 | Read data |
| mbus_ack | input | 1 | Cycle acknowledge |

## Verification
A state machine stuck in Ask or Cycle shows at once as `cpu_wait` and `mbus_req` held high past the grant or acknowledge. A skipped Release state shows as `mbus_req` dropping in the same cycle as the wait, one cycle early. A wrong bank snapshot or a wrong lane choice shows in the first bus cycle as a mismatched `mbus_addr` or strobe. A failed work-RAM check only shows when the read byte is returned after the acknowledge. The bench therefore checks every port at each of these points for every access.

// File: rtl/bwb_pkg.sv
package bwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ASK     = 2'd1,
        ST_CYCLE   = 2'd2,
        ST_RELEASE = 2'd3
    } bwb_state_t;
endpackage

// File: rtl/bwb_bank_reg.sv
module bwb_bank_reg #(
    parameter int BANK_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BANK_W-1:0] value,
    output logic [BANK_W-1:0] bank
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            bank <= '0;
        else if (load)
            bank <= value;
    end
endmodule

// File: rtl/bwb_lane_steer.sv
module bwb_lane_steer #(
    parameter int                BANK_W   = 9,
    parameter logic [BANK_W-1:0] RAM_VAL  = 9'h1FE,
    parameter logic [BANK_W-1:0] RAM_MASK = 9'h1FE,
    parameter logic [7:0]        FILL     = 8'hFF
) (
    input  logic              odd_byte,
    input  logic              is_write,
    input  logic [BANK_W-1:0] bank,
    input  logic [7:0]        wbyte,
    input  logic [15:0]       rword,
    output logic [7:0]        rbyte,
    output logic [15:0]       wword,
    output logic              upper_sel
);
    logic in_ram;
    always_comb begin
        in_ram    = ((bank & RAM_MASK) == RAM_VAL);
        upper_sel = ~odd_byte;
        wword     = {wbyte, wbyte};
        if (in_ram && !is_write)
            rbyte = FILL;
        else if (odd_byte)
            rbyte = rword[7:0];
        else
            rbyte = rword[15:8];
    end
endmodule

// File: rtl/bwb_seq.sv
module bwb_seq
    import bwb_pkg::*;
#(
    parameter int CPU_AW = 16,
    parameter int BANK_W = 9,
    localparam int WIN_W = CPU_AW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [7:0]        cpu_wdata,
    input  logic [BANK_W-1:0] bank_now,
    input  logic              grant,
    input  logic              ack,
    input  logic [7:0]        steered_rbyte,
    input  logic              upper_sel,
    output logic [WIN_W-1:0]  addr_q,
    output logic [BANK_W-1:0] bank_q,
    output logic              we_q,
    output logic [7:0]        wdata_q,
    output logic [7:0]        rdata_q,
    output logic              bus_req,
    output logic              cpu_wait,
    output logic              as_o,
    output logic              uds_o,
    output logic              lds_o
);
    bwb_state_t state, nxt;
    logic start;

    assign start = cpu_req && cpu_addr[CPU_AW-1] && (state == ST_IDLE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:    if (start) nxt = ST_ASK;
            ST_ASK:     if (grant) nxt = ST_CYCLE;
            ST_CYCLE:   if (ack)   nxt = ST_RELEASE;
            ST_RELEASE: nxt = ST_IDLE;
            default:    nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            bank_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata_q <= '0;
        end else begin
            if (start) begin
                addr_q  <= cpu_addr[WIN_W-1:0];
                bank_q  <= bank_now;
                we_q    <= cpu_we;
                wdata_q <= cpu_wdata;
            end
            if (state == ST_CYCLE && ack && !we_q)
                rdata_q <= steered_rbyte;
        end
    end

    always_comb begin
        bus_req  = (state != ST_IDLE);
        cpu_wait = (state == ST_ASK) || (state == ST_CYCLE);
        as_o     = (state == ST_CYCLE);
        uds_o    = as_o && upper_sel;
        lds_o    = as_o && !upper_sel;
    end

    // R2
    low_addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !(cpu_req && cpu_addr[CPU_AW-1])) |=> !bus_req);
    // R4
    strobe_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |-> $past(grant));
    // R8
    wait_drops_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CYCLE && ack) |=> (!cpu_wait && bus_req));
    // R9
    req_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RELEASE) |=> !bus_req);
    // R6
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        as_o |-> $countones({uds_o, lds_o}) == 1);
    // R11
    busy_snapshot_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CYCLE) |=> $stable(addr_q) && $stable(bank_q));
endmodule

// File: rtl/bank_window_bridge.sv
module bank_window_bridge #(
    parameter int                CPU_AW   = 16,
    parameter int                BANK_W   = 9,
    parameter logic [BANK_W-1:0] RAM_VAL  = 9'h1FE,
    parameter logic [BANK_W-1:0] RAM_MASK = 9'h1FE,
    parameter logic [7:0]        FILL     = 8'hFF,
    localparam int               WIN_W    = CPU_AW - 1,
    localparam int               MAIN_AW  = BANK_W + WIN_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_req,
    input  logic [CPU_AW-1:0]  cpu_addr,
    input  logic               cpu_we,
    input  logic [7:0]         cpu_wdata,
    output logic [7:0]         cpu_rdata,
    output logic               cpu_wait,
    input  logic               bank_we,
    input  logic [BANK_W-1:0]  bank_wdata,
    output logic               mbus_req,
    input  logic               mbus_grant,
    output logic [MAIN_AW-1:1] mbus_addr,
    output logic               mbus_as,
    output logic               mbus_rnw,
    output logic               mbus_uds,
    output logic               mbus_lds,
    output logic [15:0]        mbus_wdata,
    input  logic [15:0]        mbus_rdata,
    input  logic               mbus_ack
);
    logic [BANK_W-1:0] bank_now, bank_q;
    logic [WIN_W-1:0]  addr_q;
    logic              we_q, upper_sel;
    logic [7:0]        wdata_q, rbyte;

    bwb_bank_reg #(.BANK_W(BANK_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .load(bank_we), .value(bank_wdata), .bank(bank_now)
    );

    bwb_lane_steer #(.BANK_W(BANK_W), .RAM_VAL(RAM_VAL), .RAM_MASK(RAM_MASK), .FILL(FILL)) u_lane (
        .odd_byte(addr_q[0]), .is_write(we_q), .bank(bank_q), .wbyte(wdata_q),
        .rword(mbus_rdata), .rbyte(rbyte), .wword(mbus_wdata), .upper_sel(upper_sel)
    );

    bwb_seq #(.CPU_AW(CPU_AW), .BANK_W(BANK_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_we(cpu_we), .cpu_wdata(cpu_wdata), .bank_now(bank_now),
        .grant(mbus_grant), .ack(mbus_ack), .steered_rbyte(rbyte), .upper_sel(upper_sel),
        .addr_q(addr_q), .bank_q(bank_q), .we_q(we_q), .wdata_q(wdata_q),
        .rdata_q(cpu_rdata), .bus_req(mbus_req), .cpu_wait(cpu_wait),
        .as_o(mbus_as), .uds_o(mbus_uds), .lds_o(mbus_lds)
    );

    assign mbus_addr = {bank_q, addr_q[WIN_W-1:1]};
    assign mbus_rnw  = ~we_q;

    // R4
    as_only_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mbus_as |-> (mbus_grant && mbus_req));
    // R6
    write_lanes_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mbus_as && !mbus_rnw) |-> (mbus_wdata[15:8] == mbus_wdata[7:0]));
endmodule

// File: tb/bank_window_bridge_test.sv
module bank_window_bridge_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        cpu_we = 1'b0;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  cpu_rdata;
    logic        cpu_wait;
    logic        bank_we = 1'b0;
    logic [8:0]  bank_wdata = '0;
    logic        mbus_req;
    logic        mbus_grant = 1'b0;
    logic [23:1] mbus_addr;
    logic        mbus_as, mbus_rnw, mbus_uds, mbus_lds;
    logic [15:0] mbus_wdata;
    logic [15:0] mbus_rdata = '0;
    logic        mbus_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [8:0] bank_model = '0;

    always #5 clk = ~clk;

    bank_window_bridge uut (.*);

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] word_at(input logic [23:1] a);
        return {a[8:1] ^ 8'hA5, a[16:9] ^ 8'h3C};
    endfunction

    function automatic logic [7:0] exp_read(input logic [8:0] bank, input logic [23:1] a, input bit odd);
        logic [15:0] w;
        w = word_at(a);
        if (bank[8:1] == 8'hFF) return 8'hFF;
        return odd ? w[7:0] : w[15:8];
    endfunction

    task automatic load_bank(input logic [8:0] v);
        @(negedge clk);
        bank_we = 1'b1; bank_wdata = v;
        @(negedge clk);
        bank_we = 1'b0;
        bank_model = v;
    endtask

    // One full access; optional bank write and stray request while busy.
    task automatic access(input logic [15:0] a, input bit we, input logic [7:0] wd,
                          input int gdly, input int adly, input bit mid_bank, input logic [8:0] nb,
                          input bit stray);
        logic [8:0]  used_bank;
        logic [23:1] exp_addr;
        used_bank = bank_model;
        exp_addr  = {used_bank, a[14:1]};
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
        @(negedge clk);
        cpu_req = 1'b0; cpu_addr = 16'h0000;
        check(mbus_req === 1'b1, "R4 req raised", mbus_req, 1);
        check(cpu_wait === 1'b1, "R8 wait on start", cpu_wait, 1);
        for (int i = 0; i < gdly; i++) begin
            if (i == 0 && mid_bank) begin bank_we = 1'b1; bank_wdata = nb; end
            if (i == 0 && stray) begin cpu_req = 1'b1; cpu_addr = 16'hFFFF; cpu_we = ~we; end
            @(negedge clk);
            bank_we = 1'b0; cpu_req = 1'b0;
            if (i == 0 && mid_bank) bank_model = nb;
            check(mbus_as === 1'b0, "R4 no strobe before grant", mbus_as, 0);
            check(cpu_wait === 1'b1, "R8 wait held", cpu_wait, 1);
        end
        mbus_grant = 1'b1;
        @(negedge clk);
        check(mbus_as === 1'b1, "R4 strobe after grant", mbus_as, 1);
        check(mbus_addr === exp_addr, "R3/R10 address", mbus_addr, exp_addr);
        check(mbus_rnw === ~we, "R6 direction", mbus_rnw, ~we);
        check(mbus_uds === ~a[0] && mbus_lds === a[0], "R6 strobes",
              {mbus_uds, mbus_lds}, {~a[0], a[0]});
        if (we) check(mbus_wdata === {wd, wd}, "R6/R7 write replicate", mbus_wdata, {wd, wd});
        for (int i = 0; i < adly; i++) begin
            @(negedge clk);
            check(cpu_wait === 1'b1 && mbus_as === 1'b1, "R8 wait until ack", cpu_wait, 1);
        end
        mbus_ack = 1'b1;
        mbus_rdata = word_at(exp_addr);
        @(negedge clk);
        mbus_ack = 1'b0;
        mbus_rdata = 16'hDEAD;
        check(cpu_wait === 1'b0, "R8 wait drops", cpu_wait, 0);
        check(mbus_req === 1'b1, "R9 req held one more", mbus_req, 1);
        check(mbus_as === 1'b0, "R4 strobe ends", mbus_as, 0);
        if (!we) check(cpu_rdata === exp_read(used_bank, exp_addr, a[0]), "R5/R7 read byte",
                       cpu_rdata, exp_read(used_bank, exp_addr, a[0]));
        @(negedge clk);
        mbus_grant = 1'b0;
        check(mbus_req === 1'b0, "R9 req released", mbus_req, 0);
        check(cpu_wait === 1'b0, "R11 no new access", cpu_wait, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R8 actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        logic [7:0] prev;
        seed = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mbus_req === 0 && cpu_wait === 0 && mbus_as === 0 && mbus_uds === 0 && mbus_lds === 0,
              "R1 reset outputs", {mbus_req, cpu_wait, mbus_as, mbus_uds, mbus_lds}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 bank is zero: first access maps to bank 0
        access(16'h8002, 1'b0, 8'h00, 1, 0, 1'b0, 9'h0, 1'b0);
        // R2 low address ignored
        @(negedge clk);
        cpu_req = 1'b1; cpu_addr = 16'h7FFF; cpu_we = 1'b1;
        @(negedge clk);
        cpu_req = 1'b0;
        for (int i = 0; i < 4; i++) begin
            check(mbus_req === 1'b0 && cpu_wait === 1'b0, "R2 low half ignored", {mbus_req, cpu_wait}, 0);
            @(negedge clk);
        end
        // R5 lane selection, even and odd
        load_bank(9'h003);
        access(16'h8124, 1'b0, 8'h00, 0, 2, 1'b0, 9'h0, 1'b0);
        access(16'h8125, 1'b0, 8'h00, 3, 0, 1'b0, 9'h0, 1'b0);
        // R7 work RAM: read blocked both lanes, write normal
        load_bank(9'h1FE);
        access(16'h8800, 1'b0, 8'h00, 1, 1, 1'b0, 9'h0, 1'b0);
        load_bank(9'h1FF);
        access(16'hEFF3, 1'b0, 8'h00, 2, 0, 1'b0, 9'h0, 1'b0);
        access(16'hEFF2, 1'b1, 8'h5C, 1, 1, 1'b0, 9'h0, 1'b0);
        // R10 bank change mid-access, R11 stray request while busy
        load_bank(9'h042);
        access(16'hC00A, 1'b0, 8'h00, 3, 1, 1'b1, 9'h0AA, 1'b1);
        access(16'hC00B, 1'b1, 8'h91, 2, 0, 1'b0, 9'h0, 1'b0);
        // R11 read data not disturbed by write access
        prev = cpu_rdata;
        access(16'h9000, 1'b1, 8'h33, 1, 0, 1'b0, 9'h0, 1'b0);
        check(cpu_rdata === prev, "R11 rdata kept over write", cpu_rdata, prev);
        // Random mix
        for (int n = 0; n < 200; n++) begin
            logic [15:0] ra;
            logic [8:0]  rb;
            if ($urandom % 4 == 0) begin
                rb = ($urandom % 3 == 0) ? {8'hFF, 1'($urandom)} : 9'($urandom);
                load_bank(rb);
            end
            ra = {1'b1, 15'($urandom)};
            access(ra, 1'($urandom), 8'($urandom), $urandom % 4, $urandom % 3,
                   ($urandom % 8 == 0), 9'($urandom), ($urandom % 6 == 0));
        end
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule